// File: doc/BRIEF.md
# Load-Use Hazard Classifier

This block sits beside the decode stage of a small 32-bit MIPS-I style core. When a load is still on its way to a general register, the instruction that follows it is presented here together with that destination register number. One cycle later the block reports how the following instruction uses that register. It may leave it alone, only read it, only write it, or both read and write it. Stall and forwarding logic downstream decides what to do with that class.

Decoding uses fixed operand roles for each instruction format. The primary opcode field picks the format. For register-register instructions the function field picks it. For the register-immediate branch group the rt field picks it. A partial-word left/right load merges into its destination, so it is handled as a special case: a match on its destination wins over a match on its base register. Any opcode or function code that is not decoded reports no dependency.

Top module: `ldhaz_classify`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `out_class` is 0.
- R2: When `in_valid` is 1 at a rising edge, `out_valid` is 1 after that edge and `out_class` shows the class of that instruction. When `in_valid` is 0 at a rising edge, `out_valid` is 0 after it and `out_class` keeps its previous value.
- R3: The class encoding is 0 = no dependency, 1 = read and write, 2 = read only, 3 = write only. An all-zero instruction word gives 0 for every register number.
- R4: Field positions are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and function [5:0]. With opcode 0x00, function 0x00, 0x02 and 0x03 read rt and write rd. Function 0x04, 0x06, 0x07, 0x20 to 0x27, 0x2A and 0x2B read rs and rt and write rd.
- R5: With opcode 0x00, function 0x10 and 0x12 only write rd, and function 0x11 and 0x13 only read rs. Function 0x18 to 0x1B read rs and rt and write no register.
- R6: Opcodes 0x08 to 0x0E and the loads 0x20, 0x21, 0x23, 0x24 and 0x25 read rs and write rt.
- R7: For opcodes 0x22 and 0x26, a match on rt gives class 3 even when rs matches too. Otherwise a match on rs gives class 2.
- R8: Stores 0x28, 0x29, 0x2A, 0x2B and 0x2E read rs and rt. Coprocessor transfers 0x32 and 0x3A read only rs.
- R9: Opcode 0x03 writes register 31 (the LINK_REG parameter) only. Opcodes 0x04 and 0x05 read rs and rt. Opcodes 0x06 and 0x07 read rs. Opcode 0x01 with rt equal to 0x00, 0x01, 0x10 or 0x11 reads rs.
- R10: Any other opcode, function code or opcode-0x01 rt value gives class 0. Examples are opcode 0x02, opcode 0x0F, function 0x08, and opcode 0x01 with rt 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and register number are valid this cycle |
| in_insn | input | 32 | Instruction word to classify |
| in_reg | input | 5 | Register number the pending load writes |
| out_valid | output | 1 | `out_class` was updated at the last edge |
| out_class | output | 2 | Dependency class, encoding as in R3 |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 5-bit register fields and the link register at 31. With these values the last register number is reachable, so the implicit link write of opcode 0x03 can be checked against a matching and a non-matching register number. Every operand role is checked on both its matching and its non-matching side. The read-plus-write class is reached through all three pairings of a source field with a destination field. The left/right load priority is checked with rs and rt equal.

// File: rtl/ldhaz_pkg.sv
package ldhaz_pkg;

    localparam int INSN_W = 32;
    localparam int REG_W  = 5;
    localparam int OP_W   = 6;
    localparam int FN_W   = 6;

    typedef enum logic [1:0] {
        HZ_NONE   = 2'd0,
        HZ_RDWR   = 2'd1,
        HZ_RDONLY = 2'd2,
        HZ_WRONLY = 2'd3
    } hz_class_e;

    // Operand roles of one instruction
    typedef struct packed {
        logic rd_rs;     // reads rs field
        logic rd_rt;     // reads rt field
        logic wr_rd;     // writes rd field
        logic wr_rt;     // writes rt field
        logic wr_link;   // writes the link register implicitly
        logic wr_first;  // destination match outranks source match
    } roles_t;

    typedef struct packed {
        hz_class_e cls;
        logic      vld;
    } out_state_t;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
    localparam logic [OP_W-1:0] OP_REGIMM  = 6'h01;
    localparam logic [OP_W-1:0] OP_JAL     = 6'h03;

endpackage

// File: rtl/ldhaz_role_dec.sv
module ldhaz_role_dec
    import ldhaz_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [FN_W-1:0]  funct,
    input  logic [REG_W-1:0] rt_sel,
    output roles_t           roles
);

    always_comb begin
        roles = '0;
        case (op)
            OP_SPECIAL: begin
                case (funct)
                    6'h00, 6'h02, 6'h03: begin
                        roles.rd_rt = 1'b1;
                        roles.wr_rd = 1'b1;
                    end
                    6'h04, 6'h06, 6'h07,
                    6'h20, 6'h21, 6'h22, 6'h23,
                    6'h24, 6'h25, 6'h26, 6'h27,
                    6'h2A, 6'h2B: begin
                        roles.rd_rs = 1'b1;
                        roles.rd_rt = 1'b1;
                        roles.wr_rd = 1'b1;
                    end
                    6'h10, 6'h12: roles.wr_rd = 1'b1;
                    6'h11, 6'h13: roles.rd_rs = 1'b1;
                    6'h18, 6'h19, 6'h1A, 6'h1B: begin
                        roles.rd_rs = 1'b1;
                        roles.rd_rt = 1'b1;
                    end
                    default: ;
                endcase
            end
            OP_REGIMM: begin
                if (rt_sel == 5'h00 || rt_sel == 5'h01 ||
                    rt_sel == 5'h10 || rt_sel == 5'h11)
                    roles.rd_rs = 1'b1;
            end
            OP_JAL: roles.wr_link = 1'b1;
            6'h04, 6'h05: begin
                roles.rd_rs = 1'b1;
                roles.rd_rt = 1'b1;
            end
            6'h06, 6'h07: roles.rd_rs = 1'b1;
            6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E,
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25: begin
                roles.rd_rs = 1'b1;
                roles.wr_rt = 1'b1;
            end
            6'h22, 6'h26: begin
                roles.rd_rs    = 1'b1;
                roles.wr_rt    = 1'b1;
                roles.wr_first = 1'b1;
            end
            6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E: begin
                roles.rd_rs = 1'b1;
                roles.rd_rt = 1'b1;
            end
            6'h32, 6'h3A: roles.rd_rs = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ldhaz_match.sv
module ldhaz_match
    import ldhaz_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  roles_t           roles,
    input  logic [REG_W-1:0] f_rs,
    input  logic [REG_W-1:0] f_rt,
    input  logic [REG_W-1:0] f_rd,
    input  logic [REG_W-1:0] chk_reg,
    output logic             hit_read,
    output logic             hit_write,
    output logic             write_first
);

    localparam int NFLD = 3;
    localparam logic [REG_W-1:0] LINK_ID = REG_W'(LINK_REG);

    logic [REG_W-1:0] fld [NFLD];
    logic [NFLD-1:0]  fld_eq;

    assign fld[0] = f_rs;
    assign fld[1] = f_rt;
    assign fld[2] = f_rd;

    for (genvar i = 0; i < NFLD; i++) begin : g_cmp
        assign fld_eq[i] = (fld[i] == chk_reg);
    end

    assign hit_read    = (roles.rd_rs & fld_eq[0]) | (roles.rd_rt & fld_eq[1]);
    assign hit_write   = (roles.wr_rd & fld_eq[2]) | (roles.wr_rt & fld_eq[1]) |
                         (roles.wr_link & (chk_reg == LINK_ID));
    assign write_first = roles.wr_first;

endmodule

// File: rtl/ldhaz_classify.sv
module ldhaz_classify
    import ldhaz_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [REG_W-1:0]  in_reg,
    output logic              out_valid,
    output logic [1:0]        out_class
);

    roles_t     roles;
    logic       hit_read, hit_write, write_first;
    out_state_t st_d, st_q;

    ldhaz_role_dec u_dec (
        .op     (in_insn[31:26]),
        .funct  (in_insn[5:0]),
        .rt_sel (in_insn[20:16]),
        .roles  (roles)
    );

    ldhaz_match #(.LINK_REG(LINK_REG)) u_match (
        .roles       (roles),
        .f_rs        (in_insn[25:21]),
        .f_rt        (in_insn[20:16]),
        .f_rd        (in_insn[15:11]),
        .chk_reg     (in_reg),
        .hit_read    (hit_read),
        .hit_write   (hit_write),
        .write_first (write_first)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (in_insn == '0)
                st_d.cls = HZ_NONE;
            else if (write_first && hit_write)
                st_d.cls = HZ_WRONLY;
            else begin
                case ({hit_read, hit_write})
                    2'b11:   st_d.cls = HZ_RDWR;
                    2'b10:   st_d.cls = HZ_RDONLY;
                    2'b01:   st_d.cls = HZ_WRONLY;
                    default: st_d.cls = HZ_NONE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cls: HZ_NONE, vld: 1'b0};
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_class = st_q.cls;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    class_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_class));

    // R3
    zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_insn == '0) |=> out_class == 2'd0);

    // R9
    link_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_insn[31:26] == OP_JAL && in_reg == REG_W'(LINK_REG))
        |=> out_class == 2'd3);

endmodule

// File: tb/ldhaz_classify_bench.sv
`timescale 1ns/1ps
module ldhaz_classify_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic [4:0]  in_reg = '0;
    logic        out_valid;
    logic [1:0]  out_class;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    ldhaz_classify u_ldhaz_classify (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_insn   (in_insn),
        .in_reg    (in_reg),
        .out_valid (out_valid),
        .out_class (out_class)
    );

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input int fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] itype(input int op, input int rs, input int rt);
        return {6'(op), 5'(rs), 5'(rt), 16'h1234};
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // drive one valid word, sample after the registering edge
    task automatic classify(input string req, input logic [31:0] w, input int r, input int exp);
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = w;
        in_reg   = 5'(r);
        @(posedge clk);
        #1;
        check({req, " valid"}, int'(out_valid), 1);
        check(req, int'(out_class), exp);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 class in reset", int'(out_class), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 class after reset", int'(out_class), 0);
    endtask

    task automatic t_zero_word;
        classify("R3 zero word reg0", 32'h0, 0, 0);
        classify("R3 zero word reg5", 32'h0, 5, 0);
    endtask

    task automatic t_rtype;
        classify("R4 sll rt=rd", rtype(0, 3, 3, 6'h00), 3, 1);
        classify("R4 srl rt", rtype(0, 7, 9, 6'h02), 7, 2);
        classify("R4 srl rd", rtype(0, 7, 9, 6'h02), 9, 3);
        classify("R4 sra rs not read", rtype(4, 7, 9, 6'h03), 4, 0);
        classify("R4 addu rs", rtype(2, 3, 4, 6'h21), 2, 2);
        classify("R4 addu rt", rtype(2, 3, 4, 6'h21), 3, 2);
        classify("R4 addu rd", rtype(2, 3, 4, 6'h21), 4, 3);
        classify("R4 addu rs=rd", rtype(4, 3, 4, 6'h21), 4, 1);
        classify("R4 slt no match", rtype(1, 2, 5, 6'h2A), 6, 0);
        classify("R4 srlv rs", rtype(8, 9, 10, 6'h06), 8, 2);
    endtask

    task automatic t_hilo;
        classify("R5 mfhi rd", rtype(0, 0, 12, 6'h10), 12, 3);
        classify("R5 mtlo rs", rtype(13, 0, 0, 6'h13), 13, 2);
        classify("R5 mult rd field", rtype(14, 15, 16, 6'h18), 16, 0);
        classify("R5 mult rt", rtype(14, 15, 16, 6'h18), 15, 2);
    endtask

    task automatic t_imm_load;
        classify("R6 addi rs", itype(6'h08, 5, 6), 5, 2);
        classify("R6 addi rt", itype(6'h08, 5, 6), 6, 3);
        classify("R6 xori rs=rt", itype(6'h0E, 6, 6), 6, 1);
        classify("R6 lw rs=rt", itype(6'h23, 7, 7), 7, 1);
        classify("R6 lbu rt", itype(6'h24, 7, 8), 8, 3);
    endtask

    task automatic t_lwl_lwr;
        classify("R7 lwl rs=rt", itype(6'h22, 9, 9), 9, 3);
        classify("R7 lwl rs", itype(6'h22, 9, 10), 9, 2);
        classify("R7 lwr rt", itype(6'h26, 12, 11), 11, 3);
    endtask

    task automatic t_store;
        classify("R8 sw rt", itype(6'h2B, 3, 4), 4, 2);
        classify("R8 sb rs", itype(6'h28, 3, 4), 3, 2);
        classify("R8 swr rt", itype(6'h2E, 3, 4), 4, 2);
        classify("R8 lwc2 rt", itype(6'h32, 5, 6), 6, 0);
        classify("R8 swc2 rs", itype(6'h3A, 5, 6), 5, 2);
    endtask

    task automatic t_branch;
        classify("R9 jal link", itype(6'h03, 31, 31), 31, 3);
        classify("R9 jal other", itype(6'h03, 5, 5), 5, 0);
        classify("R9 beq rt", itype(6'h04, 1, 2), 2, 2);
        classify("R9 bgtz rt", itype(6'h07, 3, 4), 4, 0);
        classify("R9 bgtz rs", itype(6'h07, 3, 4), 3, 2);
        classify("R9 regimm rs", itype(6'h01, 5, 5'h10), 5, 2);
    endtask

    task automatic t_unlisted;
        classify("R10 j", itype(6'h02, 4, 4), 4, 0);
        classify("R10 lui", itype(6'h0F, 4, 4), 4, 0);
        classify("R10 funct 08", rtype(4, 0, 0, 6'h08), 4, 0);
        classify("R10 regimm rt 05", itype(6'h01, 5, 5'h05), 5, 0);
    endtask

    task automatic t_hold;
        classify("R2 setup", itype(6'h08, 5, 6), 6, 3);
        @(negedge clk);
        in_valid = 1'b0;
        in_insn  = itype(6'h08, 6, 6);
        in_reg   = 5'd6;
        @(posedge clk);
        #1;
        check("R2 valid drops", int'(out_valid), 0);
        check("R2 class holds", int'(out_class), 3);
    endtask

    initial begin
        t_reset();
        t_zero_word();
        t_rtype();
        t_hilo();
        t_imm_load();
        t_lwl_lwr();
        t_store();
        t_branch();
        t_unlisted();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule